// File: doc/BRIEF.md
# Time-Triggered Slot Scheduler

This block schedules transmissions for one node on a bus where access is planned ahead of time. A local tick counter advances once per clock and repeats a communication cycle built from up to a fixed number of slots. Each slot has a length in ticks and an owner node id. The cycle length is the sum of the lengths of the active slots. Because every transmission has a pre-planned place in the cycle, there is no arbitration.

The node may drive the bus only inside slots it owns. Even then, the transmit window is trimmed by a silent guard interval at both ends of the slot. Clock offset between nodes and message timing jitter therefore cannot push one node's transmission into a neighbour's slot. The block checks that the configured guard covers the configured worst-case skew plus jitter, and that the guard fits in every slot. If either check fails, it raises an error flag and keeps transmission off.

A correction from the clock-synchronization logic can be requested at any time. It is applied to the local counter only at the end of a cycle, so a slot already in progress is never cut short or stretched.

Top module: `tt_slot_sched`

## Requirements
- R1: While reset is held, local_time is 0, slot_index is 0, tx_enable is 0 and cycle_start is 0.
- R2: local_time increases by one every clock. In the clock after it equals cycle length minus one, it returns to 0, unless a correction is pending. The cycle length is the sum of the lengths of slots 0 to cfg_slot_count-1.
- R3: slot_index reports the slot whose tick range contains local_time. Slot k covers the ticks from the sum of the lengths of slots 0..k-1 up to, but not including, that sum plus the length of slot k.
- R4: tx_enable is 1 exactly when four conditions hold: the current slot's owner equals cfg_node_id; the offset into the slot is at least cfg_guard; the offset plus cfg_guard is below the slot length; and config_error is 0.
- R5: tx_enable stays 0 for the whole of any slot whose owner differs from cfg_node_id.
- R6: cycle_start is high for exactly one clock: the first clock of each new cycle, when local_time holds the first tick value of that cycle.
- R7: config_error is 1 whenever cfg_guard is less than cfg_max_skew plus cfg_max_jitter. While it is 1, tx_enable is 0.
- R8: config_error is 1 in any of three cases: twice cfg_guard is at least the length of some active slot; cfg_slot_count is 0; or cfg_slot_count exceeds the table size.
- R9: A pulse on sync_req captures sync_time but does not change local_time mid-cycle. At the next cycle end, local_time is loaded with the captured value instead of 0, and cycle_start is raised.
- R10: A captured sync_time that is not below the cycle length is replaced by 0 when it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| cfg_node_id | input | ID_W | Id of this node |
| cfg_slot_count | input | CNT_W | Number of active slots |
| cfg_slot_owner | input | MAX_SLOTS*ID_W | Owner id per slot, slot k at bits k*ID_W upward |
| cfg_slot_len | input | MAX_SLOTS*LEN_W | Length in ticks per slot, slot k at bits k*LEN_W upward |
| cfg_guard | input | LEN_W | Guard interval in ticks |
| cfg_max_skew | input | LEN_W | Worst-case clock skew in ticks |
| cfg_max_jitter | input | LEN_W | Worst-case transmit jitter in ticks |
| sync_req | input | 1 | Request a counter correction |
| sync_time | input | TIME_W | Value to load at the next cycle end |
| tx_enable | output | 1 | Node may transmit |
| slot_index | output | IDX_W | Current slot number |
| cycle_start | output | 1 | One-clock pulse at the first tick of a cycle |
| config_error | output | 1 | Schedule or guard settings invalid |
| local_time | output | TIME_W | Tick count within the cycle |

## Verification
The bench uses a three-slot schedule with two owned slots around one foreign slot. It walks ticks at the slot edges and at the guard edges, which separates an off-by-one guard from a correct one and a foreign slot from an owned one. Changing the node id to the middle slot's owner shows that the window follows ownership rather than slot position. Corrections are issued mid-cycle, with in-range and out-of-range values, to show that they are deferred to the cycle end and clamped. Guard-versus-skew and guard-versus-length violations are applied one at a time, each with its own recovery, so each error cause is seen alone.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;

    localparam int DEF_ID_W      = 4;
    localparam int DEF_LEN_W     = 16;
    localparam int DEF_MAX_SLOTS = 16;

    // True when a guard of g ticks at each end still leaves a non-empty window.
    function automatic logic guard_fits(input logic [31:0] g, input logic [31:0] len);
        return ({g, 1'b0} < {1'b0, len});
    endfunction

endpackage

// File: rtl/tt_slot_table.sv
module tt_slot_table #(
    parameter int MAX_SLOTS = 16,
    parameter int LEN_W     = 16,
    parameter int ID_W      = 4,
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 5,
    parameter int TIME_W    = 20
) (
    input  logic [MAX_SLOTS*LEN_W-1:0] len_flat,
    input  logic [MAX_SLOTS*ID_W-1:0]  owner_flat,
    input  logic [CNT_W-1:0]           count,
    input  logic [TIME_W-1:0]          cur_time,
    output logic [TIME_W-1:0]          cycle_len,
    output logic [IDX_W-1:0]           slot_idx,
    output logic [TIME_W-1:0]          slot_start,
    output logic [LEN_W-1:0]           slot_len,
    output logic [ID_W-1:0]            slot_owner
);

    logic [TIME_W-1:0]    ends [MAX_SLOTS];
    logic [MAX_SLOTS-1:0] active;
    logic [MAX_SLOTS-1:0] passed;

    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_prefix
        logic [TIME_W-1:0] len_g;
        assign active[g] = (CNT_W'(g) < count);
        assign len_g     = active[g] ? TIME_W'(len_flat[g*LEN_W +: LEN_W]) : '0;
        if (g == 0) begin : g_first
            assign ends[g] = len_g;
        end else begin : g_next
            assign ends[g] = ends[g-1] + len_g;
        end
        assign passed[g] = active[g] && (cur_time >= ends[g]);
    end

    assign cycle_len = ends[MAX_SLOTS-1];

    logic [CNT_W-1:0] n_passed;

    always_comb begin
        n_passed = CNT_W'($countones(passed));
        if (count != '0 && n_passed >= count) begin
            slot_idx = IDX_W'(count - 1'b1);
        end else begin
            slot_idx = IDX_W'(n_passed);
        end
        slot_start = '0;
        for (int i = 1; i < MAX_SLOTS; i++) begin
            if (slot_idx == IDX_W'(i)) begin
                slot_start = ends[i-1];
            end
        end
        slot_len   = len_flat[slot_idx*LEN_W +: LEN_W];
        slot_owner = owner_flat[slot_idx*ID_W +: ID_W];
    end

endmodule

// File: rtl/tt_guard_check.sv
module tt_guard_check
    import tt_sched_pkg::*;
#(
    parameter int MAX_SLOTS = 16,
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 5
) (
    input  logic [MAX_SLOTS*LEN_W-1:0] len_flat,
    input  logic [CNT_W-1:0]           count,
    input  logic [LEN_W-1:0]           guard,
    input  logic [LEN_W-1:0]           skew,
    input  logic [LEN_W-1:0]           jitter,
    output logic                       err
);

    logic [LEN_W:0]       margin;
    logic                 short_guard;
    logic                 bad_count;
    logic [MAX_SLOTS-1:0] no_room;

    assign margin      = {1'b0, skew} + {1'b0, jitter};
    assign short_guard = ({1'b0, guard} < margin);
    assign bad_count   = (count == '0) || (count > CNT_W'(MAX_SLOTS));

    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_room
        assign no_room[g] = (CNT_W'(g) < count) &&
                            !guard_fits(32'(guard), 32'(len_flat[g*LEN_W +: LEN_W]));
    end

    assign err = short_guard || bad_count || (|no_room);

endmodule

// File: rtl/tt_tx_window.sv
module tt_tx_window #(
    parameter int LEN_W  = 16,
    parameter int ID_W   = 4,
    parameter int TIME_W = 20
) (
    input  logic [TIME_W-1:0] cur_time,
    input  logic [TIME_W-1:0] slot_start,
    input  logic [LEN_W-1:0]  slot_len,
    input  logic [ID_W-1:0]   slot_owner,
    input  logic [ID_W-1:0]   node_id,
    input  logic [LEN_W-1:0]  guard,
    input  logic              allow,
    output logic              tx
);

    logic [TIME_W-1:0] offset;
    logic [TIME_W:0]   tail;
    logic              past_lead;
    logic              before_trail;

    assign offset       = cur_time - slot_start;
    assign tail         = {1'b0, offset} + (TIME_W+1)'(guard);
    assign past_lead    = (offset >= TIME_W'(guard));
    assign before_trail = (tail < (TIME_W+1)'(slot_len));
    assign tx           = allow && (slot_owner == node_id) && past_lead && before_trail;

endmodule

// File: rtl/tt_slot_sched.sv
module tt_slot_sched
    import tt_sched_pkg::*;
#(
    parameter int ID_W      = DEF_ID_W,
    parameter int LEN_W     = DEF_LEN_W,
    parameter int MAX_SLOTS = DEF_MAX_SLOTS,
    localparam int IDX_W    = $clog2(MAX_SLOTS),
    localparam int CNT_W    = $clog2(MAX_SLOTS + 1),
    localparam int TIME_W   = LEN_W + IDX_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ID_W-1:0]            cfg_node_id,
    input  logic [CNT_W-1:0]           cfg_slot_count,
    input  logic [MAX_SLOTS*ID_W-1:0]  cfg_slot_owner,
    input  logic [MAX_SLOTS*LEN_W-1:0] cfg_slot_len,
    input  logic [LEN_W-1:0]           cfg_guard,
    input  logic [LEN_W-1:0]           cfg_max_skew,
    input  logic [LEN_W-1:0]           cfg_max_jitter,
    input  logic                       sync_req,
    input  logic [TIME_W-1:0]          sync_time,
    output logic                       tx_enable,
    output logic [IDX_W-1:0]           slot_index,
    output logic                       cycle_start,
    output logic                       config_error,
    output logic [TIME_W-1:0]          local_time
);

    typedef struct packed {
        logic [TIME_W-1:0] tm;
        logic              pend;
        logic [TIME_W-1:0] pend_val;
        logic              first;
        logic              live;
    } state_t;

    state_t state_d, state_q;

    logic [TIME_W-1:0] cycle_len;
    logic [TIME_W-1:0] slot_start;
    logic [LEN_W-1:0]  slot_len;
    logic [ID_W-1:0]   slot_owner;
    logic [IDX_W-1:0]  slot_idx;
    logic              cfg_bad;
    logic              tx_raw;
    logic              at_end;

    tt_slot_table #(
        .MAX_SLOTS(MAX_SLOTS), .LEN_W(LEN_W), .ID_W(ID_W),
        .IDX_W(IDX_W), .CNT_W(CNT_W), .TIME_W(TIME_W)
    ) u_table (
        .len_flat   (cfg_slot_len),
        .owner_flat (cfg_slot_owner),
        .count      (cfg_slot_count),
        .cur_time   (state_q.tm),
        .cycle_len  (cycle_len),
        .slot_idx   (slot_idx),
        .slot_start (slot_start),
        .slot_len   (slot_len),
        .slot_owner (slot_owner)
    );

    tt_guard_check #(
        .MAX_SLOTS(MAX_SLOTS), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_guard (
        .len_flat (cfg_slot_len),
        .count    (cfg_slot_count),
        .guard    (cfg_guard),
        .skew     (cfg_max_skew),
        .jitter   (cfg_max_jitter),
        .err      (cfg_bad)
    );

    tt_tx_window #(
        .LEN_W(LEN_W), .ID_W(ID_W), .TIME_W(TIME_W)
    ) u_window (
        .cur_time   (state_q.tm),
        .slot_start (slot_start),
        .slot_len   (slot_len),
        .slot_owner (slot_owner),
        .node_id    (cfg_node_id),
        .guard      (cfg_guard),
        .allow      (state_q.live && !cfg_bad),
        .tx         (tx_raw)
    );

    assign at_end = (({1'b0, state_q.tm} + 1'b1) >= {1'b0, cycle_len});

    always_comb begin
        state_d       = state_q;
        state_d.live  = 1'b1;
        state_d.first = at_end;
        if (at_end) begin
            if (state_q.pend && (state_q.pend_val < cycle_len)) begin
                state_d.tm = state_q.pend_val;
            end else begin
                state_d.tm = '0;
            end
            state_d.pend = 1'b0;
        end else begin
            state_d.tm = state_q.tm + 1'b1;
        end
        if (sync_req) begin
            state_d.pend     = 1'b1;
            state_d.pend_val = sync_time;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tx_enable    = tx_raw;
    assign slot_index   = slot_idx;
    assign cycle_start  = state_q.first;
    assign config_error = cfg_bad;
    assign local_time   = state_q.tm;

endmodule

// File: rtl/tt_slot_sched_chk.sv
module tt_slot_sched_chk #(
    parameter int ID_W   = 4,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5,
    parameter int TIME_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_enable,
    input logic              config_error,
    input logic              cycle_start,
    input logic [TIME_W-1:0] local_time,
    input logic [TIME_W-1:0] cycle_len,
    input logic [ID_W-1:0]   slot_owner,
    input logic [ID_W-1:0]   cfg_node_id,
    input logic [IDX_W-1:0]  slot_index,
    input logic [CNT_W-1:0]  cfg_slot_count
);

    logic seen_q;
    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    // R7
    err_blocks_tx_chk: assert property (@(posedge clk) disable iff (rst)
        config_error |-> !tx_enable);

    // R4
    own_slot_only_chk: assert property (@(posedge clk) disable iff (rst)
        tx_enable |-> (slot_owner == cfg_node_id));

    // R2
    steady_count_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !cycle_start) |-> (local_time == $past(local_time) + 1'b1));

    // R6
    start_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && cycle_start) |-> (({1'b0, $past(local_time)} + 1'b1) >= {1'b0, $past(cycle_len)}));

    // R3
    index_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        !config_error |-> (CNT_W'(slot_index) < cfg_slot_count));

endmodule

bind tt_slot_sched tt_slot_sched_chk #(
    .ID_W(ID_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .TIME_W(TIME_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .tx_enable      (tx_enable),
    .config_error   (config_error),
    .cycle_start    (cycle_start),
    .local_time     (local_time),
    .cycle_len      (cycle_len),
    .slot_owner     (slot_owner),
    .cfg_node_id    (cfg_node_id),
    .slot_index     (slot_index),
    .cfg_slot_count (cfg_slot_count)
);

// File: tb/tt_slot_sched_test.sv
module tt_slot_sched_test;

    localparam int PERIOD    = 10;
    localparam int ID_W      = 4;
    localparam int LEN_W     = 16;
    localparam int MAX_SLOTS = 16;
    localparam int IDX_W     = 4;
    localparam int CNT_W     = 5;
    localparam int TIME_W    = 20;

    // time, expected slot, expected tx (slots: 20 own, 10 foreign, 16 own; guard 3)
    localparam int NVEC = 14;
    localparam int VEC [NVEC][3] = '{
        '{0, 0, 0}, '{2, 0, 0}, '{3, 0, 1}, '{16, 0, 1}, '{17, 0, 0},
        '{19, 0, 0}, '{20, 1, 0}, '{25, 1, 0}, '{29, 1, 0}, '{30, 2, 0},
        '{33, 2, 1}, '{42, 2, 1}, '{43, 2, 0}, '{45, 2, 0}
    };

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [ID_W-1:0]            cfg_node_id = 4'd5;
    logic [CNT_W-1:0]           cfg_slot_count = 5'd3;
    logic [MAX_SLOTS*ID_W-1:0]  cfg_slot_owner = '0;
    logic [MAX_SLOTS*LEN_W-1:0] cfg_slot_len = '0;
    logic [LEN_W-1:0]           cfg_guard = 16'd3;
    logic [LEN_W-1:0]           cfg_max_skew = 16'd1;
    logic [LEN_W-1:0]           cfg_max_jitter = 16'd2;
    logic                       sync_req = 1'b0;
    logic [TIME_W-1:0]          sync_time = '0;
    logic                       tx_enable;
    logic [IDX_W-1:0]           slot_index;
    logic                       cycle_start;
    logic                       config_error;
    logic [TIME_W-1:0]          local_time;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    tt_slot_sched uut (
        .clk(clk), .rst(rst), .cfg_node_id(cfg_node_id), .cfg_slot_count(cfg_slot_count),
        .cfg_slot_owner(cfg_slot_owner), .cfg_slot_len(cfg_slot_len), .cfg_guard(cfg_guard),
        .cfg_max_skew(cfg_max_skew), .cfg_max_jitter(cfg_max_jitter),
        .sync_req(sync_req), .sync_time(sync_time), .tx_enable(tx_enable),
        .slot_index(slot_index), .cycle_start(cycle_start),
        .config_error(config_error), .local_time(local_time)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at time %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_time(input int t);
        int n = 0;
        while (int'(local_time) != t && n < 200) begin
            @(negedge clk);
            n++;
        end
        check("R2 reach tick", int'(local_time), t);
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cfg_slot_owner[0*ID_W +: ID_W]   = 4'd5;
        cfg_slot_owner[1*ID_W +: ID_W]   = 4'd2;
        cfg_slot_owner[2*ID_W +: ID_W]   = 4'd5;
        cfg_slot_len[0*LEN_W +: LEN_W]   = 16'd20;
        cfg_slot_len[1*LEN_W +: LEN_W]   = 16'd10;
        cfg_slot_len[2*LEN_W +: LEN_W]   = 16'd16;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 time", int'(local_time), 0);
        check("R1 slot", int'(slot_index), 0);
        check("R1 tx", int'(tx_enable), 0);
        check("R1 start", int'(cycle_start), 0);
        rst = 1'b0;

        // Table walk: R3 slot index, R4 own-slot guard window, R5 foreign slot
        for (int v = 0; v < NVEC; v++) begin
            wait_time(VEC[v][0]);
            check("R3 slot", int'(slot_index), VEC[v][1]);
            check((VEC[v][1] == 1) ? "R5 tx" : "R4 tx", int'(tx_enable), VEC[v][2]);
        end

        // R2 wrap and R6 single pulse
        @(negedge clk);
        check("R2 wrap", int'(local_time), 0);
        check("R6 pulse", int'(cycle_start), 1);
        @(negedge clk);
        check("R6 pulse end", int'(cycle_start), 0);
        check("R2 step", int'(local_time), 1);

        // R9 deferred correction
        wait_time(10);
        sync_req = 1'b1; sync_time = 20'd7;
        @(negedge clk);
        sync_req = 1'b0;
        check("R9 no mid-cycle load", int'(local_time), 11);
        wait_time(45);
        @(negedge clk);
        check("R9 loaded", int'(local_time), 7);
        check("R9 start", int'(cycle_start), 1);

        // R10 out-of-range correction
        wait_time(10);
        sync_req = 1'b1; sync_time = 20'd100;
        @(negedge clk);
        sync_req = 1'b0;
        wait_time(45);
        @(negedge clk);
        check("R10 clamp", int'(local_time), 0);

        // R4 ownership follows node id
        cfg_node_id = 4'd2;
        wait_time(23);
        check("R4 middle owner", int'(tx_enable), 1);
        wait_time(27);
        check("R4 trail guard", int'(tx_enable), 0);
        wait_time(5);
        check("R5 other owner", int'(tx_enable), 0);
        cfg_node_id = 4'd5;

        // R7 guard below skew plus jitter
        cfg_max_jitter = 16'd3;
        wait_time(8);
        check("R7 flag", int'(config_error), 1);
        check("R7 tx held", int'(tx_enable), 0);
        cfg_max_jitter = 16'd2;
        @(negedge clk);
        check("R7 clear", int'(config_error), 0);
        check("R4 tx back", int'(tx_enable), 1);

        // R8 guard too long for a slot, bad counts
        cfg_slot_len[2*LEN_W +: LEN_W] = 16'd6;
        @(negedge clk);
        check("R8 no room", int'(config_error), 1);
        check("R8 tx held", int'(tx_enable), 0);
        cfg_slot_len[2*LEN_W +: LEN_W] = 16'd7;
        @(negedge clk);
        check("R8 room ok", int'(config_error), 0);
        cfg_slot_count = 5'd0;
        @(negedge clk);
        check("R8 zero count", int'(config_error), 1);
        cfg_slot_count = 5'd17;
        @(negedge clk);
        check("R8 big count", int'(config_error), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule